// File: doc/BRIEF.md
# Byte-Serial SPI Master Shift Engine

This block is the serial core of an SPI master. A register file presents its settings as plain inputs: clock polarity, sampling phase, bit order, a chip-select number with an optional software-held level, a receive-drop switch, and two 24-bit byte counts. One count is the length of the whole burst. The other is how many leading bytes of that burst are taken from the transmit queue. A one-cycle start request launches a burst. The engine then pulls bytes from an external transmit queue, shifts each one out MSB-first or LSB-first while it captures the incoming line, and pushes every received byte into an external receive queue unless receive-drop is set. Bytes past the transmit count are sent as zero.

Pacing comes from an external half-period strobe, so the divider stays outside the block. Each strobe moves the serial clock by one half period. The engine reports a busy level for as long as the burst runs and a one-cycle completion pulse when it ends. The serial clock is held low until the bus-enable input is set, and a start request made while the bus is disabled does nothing.

Top module: `spi_xfer_engine`

## Requirements
- R1: Under reset, `sclk` and `mosi` are 0, every `cs_n` line is 1, and `busy`, `done`, `tx_pop` and `rx_push` are 0.
- R2: While `bus_en` is 0 and no burst runs, `sclk` is 0 whatever `cpol` is, and a `start` pulse is ignored: `busy` stays 0 and `done` is never raised.
- R3: A `start` accepted with a nonzero `burst_len` makes `busy` 1 from the next cycle. `done` pulses for exactly one cycle at the end of the burst, in the same cycle that `busy` returns to 0. A `start` seen while `busy` is 1 is ignored.
- R4: With `bus_en` set and no burst running, `sclk` rests at `cpol`. A burst of N bytes makes exactly 16·N `sclk` transitions, which is 8 bits per byte.
- R5: With `cpha`=0 the peer's data is sampled on the first (leading) `sclk` edge of every bit and `mosi` changes on the trailing edge, with the first bit already present before edge one. With `cpha`=1 `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R6: With `lsb_first`=0 bit 7 of each byte travels first on both lines. With `lsb_first`=1 bit 0 travels first.
- R7: Byte k of the burst (k from 0) is popped from the transmit queue when k < `tx_len`, so `min(tx_len, burst_len)` pops happen in total. Every later byte is shifted out as 0x00, and `tx_pop` is only raised while `tx_valid` is 1.
- R8: With `rx_discard`=0 each completed byte is pushed once on `rx_data` with `rx_push`. With `rx_discard`=1 no push happens during the burst.
- R9: A `start` accepted with `burst_len`=0 raises `done` in the next cycle, without `busy`, `sclk` movement or a chip-select change.
- R10: With `cs_manual`=0 the line `cs_n[cs_sel]` goes low for the whole burst. It falls at least one half period before the first `sclk` edge and rises at least one half period after the last one. At most one `cs_n` line is low at any time.
- R11: With `cs_manual`=1 the line `cs_n[cs_sel]` simply follows `cs_level`, and a burst does not change it.
- R12: When the next byte must come from the transmit queue and `tx_valid` is 0, the engine waits with `sclk` still and `busy` held, then continues once data arrives.
- R13: `burst_len`, `tx_len`, `cpha`, `cpol`, `lsb_first` and `rx_discard` are captured when `start` is accepted. Changing them during a burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus enable; gates start and the serial clock |
| start | input | 1 | One-cycle request to begin a burst |
| cpha | input | 1 | Sampling phase select |
| cpol | input | 1 | Idle level of the serial clock |
| lsb_first | input | 1 | 1 shifts bit 0 first, 0 shifts bit 7 first |
| rx_discard | input | 1 | 1 drops received bytes |
| cs_sel | input | 2 | Chip-select line number |
| cs_manual | input | 1 | 1 hands the selected line to cs_level |
| cs_level | input | 1 | Level of the selected line in manual mode |
| burst_len | input | 24 | Total bytes in the burst |
| tx_len | input | 24 | Leading bytes taken from the transmit queue |
| half_tick | input | 1 | One-cycle strobe per serial half period |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle burst-complete pulse |
| tx_data | input | 8 | Head byte of the transmit queue |
| tx_valid | input | 1 | Transmit queue is not empty |
| tx_pop | output | 1 | Removes the head byte from the transmit queue |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Writes rx_data into the receive queue |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines, active low |

## Verification
Random bursts of one to six bytes cover all four polarity and phase pairs and both bit orders. A bench peer model returns random bytes and records what arrives on `mosi`, so a phase fault appears as a shifted byte and an order fault as a mirrored byte. Transmit counts are drawn both under and over the burst length, which separates the dummy-zero tail from queue data and catches a pop count that ignores the shorter of the two. Directed cases add a zero-length burst, a disabled bus, a starved queue, a repeated start, manual chip-select, and settings changed mid-burst, which exposes any setting that is used live instead of captured.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int unsigned BYTE_W         = 8;
    localparam int unsigned EDGES_PER_BYTE = 2 * BYTE_W;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_LEAD,
        XS_LOAD,
        XS_SHIFT,
        XS_TRAIL
    } xfer_state_e;

    // settings captured at the start of a burst
    typedef struct packed {
        logic cpha;
        logic cpol;
        logic lsb_first;
        logic rx_discard;
    } xfer_mode_t;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                start,
    input  xfer_mode_t          mode_in,
    input  logic [CNT_W-1:0]    burst_len,
    input  logic [CNT_W-1:0]    tx_len,
    input  logic                half_tick,
    input  logic                tx_valid,
    input  logic [BYTE_W-1:0]   tx_data,
    output logic                busy,
    output logic                done,
    output xfer_mode_t          mode_q,
    output logic                sck_toggled,
    output logic                tx_pop,
    output logic                sh_load,
    output logic [BYTE_W-1:0]   sh_load_byte,
    output logic                sh_drive,
    output logic                sh_sample,
    output logic                rx_push
);

    localparam int unsigned EDGE_W = $clog2(EDGES_PER_BYTE + 1);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES_PER_BYTE);

    typedef struct packed {
        xfer_state_e        st;
        logic [CNT_W-1:0]   idx;
        logic [CNT_W-1:0]   burst;
        logic [CNT_W-1:0]   txn;
        logic [EDGE_W-1:0]  edge_n;
        logic               sck;
        xfer_mode_t         mode;
        logic               done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic              need_tx;
    logic [EDGE_W-1:0] edge_nx;
    logic              leading;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.done  = 1'b0;
        tx_pop       = 1'b0;
        sh_load      = 1'b0;
        sh_load_byte = '0;
        sh_drive     = 1'b0;
        sh_sample    = 1'b0;
        rx_push      = 1'b0;
        need_tx      = (ctrl_q.idx < ctrl_q.txn);
        edge_nx      = ctrl_q.edge_n + EDGE_W'(1);
        leading      = edge_nx[0];

        unique case (ctrl_q.st)
            XS_IDLE: begin
                if (start && bus_en) begin
                    if (burst_len == '0) begin
                        ctrl_d.done = 1'b1;
                    end else begin
                        ctrl_d.st    = XS_LEAD;
                        ctrl_d.idx   = '0;
                        ctrl_d.burst = burst_len;
                        ctrl_d.txn   = tx_len;
                        ctrl_d.mode  = mode_in;
                        ctrl_d.sck   = 1'b0;
                    end
                end
            end
            XS_LEAD: begin
                if (half_tick) begin
                    ctrl_d.st = XS_LOAD;
                end
            end
            XS_LOAD: begin
                if (!need_tx || tx_valid) begin
                    sh_load       = 1'b1;
                    tx_pop        = need_tx;
                    sh_load_byte  = need_tx ? tx_data : '0;
                    ctrl_d.edge_n = '0;
                    ctrl_d.st     = XS_SHIFT;
                end
            end
            XS_SHIFT: begin
                if (half_tick) begin
                    ctrl_d.sck    = ~ctrl_q.sck;
                    ctrl_d.edge_n = edge_nx;
                    if (ctrl_q.mode.cpha) begin
                        sh_drive  = leading;
                        sh_sample = !leading;
                    end else begin
                        sh_sample = leading;
                        sh_drive  = !leading && (edge_nx != LAST_EDGE);
                    end
                    if (edge_nx == LAST_EDGE) begin
                        rx_push = !ctrl_q.mode.rx_discard;
                        if (ctrl_q.idx + CNT_W'(1) == ctrl_q.burst) begin
                            ctrl_d.st = XS_TRAIL;
                        end else begin
                            ctrl_d.idx = ctrl_q.idx + CNT_W'(1);
                            ctrl_d.st  = XS_LOAD;
                        end
                    end
                end
            end
            XS_TRAIL: begin
                if (half_tick) begin
                    ctrl_d.st   = XS_IDLE;
                    ctrl_d.done = 1'b1;
                end
            end
            default: ctrl_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: XS_IDLE, idx: '0, burst: '0, txn: '0, edge_n: '0,
                        sck: 1'b0, mode: '0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy        = (ctrl_q.st != XS_IDLE);
    assign done        = ctrl_q.done;
    assign mode_q      = ctrl_q.mode;
    assign sck_toggled = ctrl_q.sck;

endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter
    import spi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              drive,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_word
);

    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              mosi;
    } shift_t;

    shift_t sh_d, sh_q;
    logic [BYTE_W-1:0] rx_next;

    function automatic logic head_bit(input logic [BYTE_W-1:0] b, input logic lsb);
        return lsb ? b[0] : b[BYTE_W-1];
    endfunction

    function automatic logic [BYTE_W-1:0] advance(input logic [BYTE_W-1:0] b, input logic lsb);
        return lsb ? (b >> 1) : (b << 1);
    endfunction

    always_comb begin
        sh_d    = sh_q;
        rx_next = lsb_first ? {miso, sh_q.rx[BYTE_W-1:1]}
                            : {sh_q.rx[BYTE_W-2:0], miso};
        if (load) begin
            if (cpha) begin
                sh_d.tx = load_byte;
            end else begin
                sh_d.mosi = head_bit(load_byte, lsb_first);
                sh_d.tx   = advance(load_byte, lsb_first);
            end
        end else if (drive) begin
            sh_d.mosi = head_bit(sh_q.tx, lsb_first);
            sh_d.tx   = advance(sh_q.tx, lsb_first);
        end
        if (sample) begin
            sh_d.rx = rx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi    = sh_q.mosi;
    assign rx_word = sample ? rx_next : sh_q.rx;

endmodule

// File: rtl/spi_xfer_cs.sv
module spi_xfer_cs #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic              cs_manual,
    input  logic              cs_level,
    input  logic              frame,
    output logic [NUM_CS-1:0] cs_n
);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        always_comb begin
            if (cs_sel == SEL_W'(g)) begin
                cs_n[g] = cs_manual ? cs_level : !frame;
            end else begin
                cs_n[g] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              start,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              lsb_first,
    input  logic              rx_discard,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic              cs_manual,
    input  logic              cs_level,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              half_tick,
    output logic              busy,
    output logic              done,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_pop,
    output logic [7:0]        rx_data,
    output logic              rx_push,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    xfer_mode_t        mode_in, mode_q;
    logic              sck_toggled;
    logic              sh_load, sh_drive, sh_sample;
    logic [BYTE_W-1:0] sh_load_byte;

    assign mode_in = '{cpha: cpha, cpol: cpol, lsb_first: lsb_first, rx_discard: rx_discard};

    spi_xfer_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_en       (bus_en),
        .start        (start),
        .mode_in      (mode_in),
        .burst_len    (burst_len),
        .tx_len       (tx_len),
        .half_tick    (half_tick),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .busy         (busy),
        .done         (done),
        .mode_q       (mode_q),
        .sck_toggled  (sck_toggled),
        .tx_pop       (tx_pop),
        .sh_load      (sh_load),
        .sh_load_byte (sh_load_byte),
        .sh_drive     (sh_drive),
        .sh_sample    (sh_sample),
        .rx_push      (rx_push)
    );

    spi_xfer_shifter i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpha      (mode_q.cpha),
        .lsb_first (mode_q.lsb_first),
        .load      (sh_load),
        .load_byte (sh_load_byte),
        .drive     (sh_drive),
        .sample    (sh_sample),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );

    spi_xfer_cs #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_cs (
        .cs_sel    (cs_sel),
        .cs_manual (cs_manual),
        .cs_level  (cs_level),
        .frame     (busy),
        .cs_n      (cs_n)
    );

    // idle level follows cpol only once the bus is enabled
    assign sclk = busy ? (mode_q.cpol ^ sck_toggled) : (bus_en & cpol);

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              start,
    input logic              rx_discard,
    input logic [CNT_W-1:0]  burst_len,
    input logic              busy,
    input logic              done,
    input logic              tx_pop,
    input logic              tx_valid,
    input logic              rx_push,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs_n
);

    logic accept;
    logic drop_q;

    assign accept = start && bus_en && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (accept) begin
            drop_q <= rx_discard;
        end
    end

    p_gate_sclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en && !busy) |-> (sclk == 1'b0));

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && burst_len != '0) |=> busy);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(start && bus_en && burst_len == '0)));

    p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    p_drop_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !drop_q);

    p_zero_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && burst_len == '0) |=> (done && !busy));

    p_one_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.CNT_W(CNT_W), .NUM_CS(NUM_CS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .start      (start),
    .rx_discard (rx_discard),
    .burst_len  (burst_len),
    .busy       (busy),
    .done       (done),
    .tx_pop     (tx_pop),
    .tx_valid   (tx_valid),
    .rx_push    (rx_push),
    .sclk       (sclk),
    .cs_n       (cs_n)
);

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;

    localparam int HP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, start = 1'b0;
    logic        cpha = 1'b0, cpol = 1'b0, lsb_first = 1'b0, rx_discard = 1'b0;
    logic [1:0]  cs_sel = 2'd0;
    logic        cs_manual = 1'b0, cs_level = 1'b1;
    logic [23:0] burst_len = '0, tx_len = '0;
    logic        half_tick;
    logic        busy, done, tx_pop, rx_push, sclk, mosi;
    logic        miso = 1'b0;
    logic [7:0]  tx_data, rx_data;
    logic        tx_valid;
    logic [3:0]  cs_n;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    int tk;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk <= 0;
        else        tk <= (tk == HP - 1) ? 0 : tk + 1;
    end
    assign half_tick = (tk == HP - 1);

    logic [7:0] tx_mem [0:255];
    int tx_rd, tx_avail = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tx_rd <= 0;
        else if (tx_pop) tx_rd <= tx_rd + 1;
    end
    assign tx_valid = (tx_rd < tx_avail);
    assign tx_data  = tx_mem[tx_rd % 256];

    spi_xfer_engine i_spi_xfer_engine (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .start(start),
        .cpha(cpha), .cpol(cpol), .lsb_first(lsb_first), .rx_discard(rx_discard),
        .cs_sel(cs_sel), .cs_manual(cs_manual), .cs_level(cs_level),
        .burst_len(burst_len), .tx_len(tx_len), .half_tick(half_tick),
        .busy(busy), .done(done), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // peer model state
    logic       m_cpol = 0, m_cpha = 0, m_lsb = 0;
    int         m_sel = 0;
    logic [7:0] slave_b [0:15];
    logic [7:0] mosi_got [0:15];
    logic [7:0] rx_got [0:15];
    logic [7:0] mo_sh = 0;
    int n_mo = 0, n_rx = 0, edges = 0, any_edges = 0, done_cnt = 0;
    int bitcnt = 0, byte_i = 0, cyc = 0;
    int cs_at = 0, last_edge_at = 0, lead_gap = -1, trail_gap = -1;
    bit first_seen = 0;
    logic prev_sclk = 0, prev_csa = 0;

    function automatic logic bitof(input logic [7:0] b, input int k, input logic lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    function automatic logic [7:0] exp_mosi(input int i, input int txc, input int base);
        return (i < txc) ? tx_mem[(base + i) % 256] : 8'h00;
    endfunction

    always @(negedge clk) begin
        logic csa;
        logic leading;
        cyc++;
        csa = (cs_n[m_sel] == 1'b0);
        if (csa && !prev_csa) begin
            cs_at = cyc; bitcnt = 0; byte_i = 0; first_seen = 0;
            if (!m_cpha) miso = bitof(slave_b[0], 0, m_lsb);
        end
        if (!csa && prev_csa) trail_gap = cyc - last_edge_at;
        if (sclk != prev_sclk) any_edges++;
        if (csa && sclk != prev_sclk) begin
            edges++;
            if (!first_seen) begin lead_gap = cyc - cs_at; first_seen = 1; end
            last_edge_at = cyc;
            leading = (sclk != m_cpol);
            if (leading == !m_cpha) begin
                mo_sh = m_lsb ? {mosi, mo_sh[7:1]} : {mo_sh[6:0], mosi};
                bitcnt++;
                if (bitcnt == 8) begin
                    if (n_mo < 16) mosi_got[n_mo] = mo_sh;
                    n_mo++; bitcnt = 0; byte_i++;
                end
            end else begin
                miso = bitof(slave_b[byte_i % 16], bitcnt, m_lsb);
            end
        end
        if (rx_push) begin
            if (n_rx < 16) rx_got[n_rx] = rx_data;
            n_rx++;
        end
        if (done) done_cnt++;
        prev_sclk = sclk;
        prev_csa  = csa;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(input int burst, input int txc, input bit cp, input bit ch,
                            input bit lsb, input bit disc, input int sel,
                            input bit manual, input bit stall, input bit restart);
        int base, pops;
        @(negedge clk);
        cpol = cp; cpha = ch; lsb_first = lsb; rx_discard = disc;
        cs_sel = 2'(sel); cs_manual = manual; cs_level = 1'b1;
        burst_len = 24'(burst); tx_len = 24'(txc);
        m_cpol = cp; m_cpha = ch; m_lsb = lsb; m_sel = sel;
        for (int i = 0; i < 16; i++) slave_b[i] = 8'($urandom);
        base = tx_rd;
        for (int i = 0; i < txc; i++) tx_mem[(base + i) % 256] = 8'($urandom);
        tx_avail = stall ? tx_rd : tx_rd + txc;
        n_mo = 0; n_rx = 0; edges = 0; done_cnt = 0; lead_gap = -1; trail_gap = -1;
        @(negedge clk);
        if (manual) begin cs_level = 1'b0; @(negedge clk); end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
        // R13: disturb the live settings, the burst must keep the captured ones
        burst_len = 24'(burst + 3); tx_len = 24'd0;
        cpha = ~ch; lsb_first = ~lsb; rx_discard = ~disc;
        if (restart) begin
            repeat (20) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        if (stall) begin
            repeat (60) @(negedge clk);
            chk(edges == 0, "R12 sclk still while starved", edges, 0);
            chk(busy == 1'b1, "R12 busy while starved", int'(busy), 1);
            tx_avail = tx_rd + txc;
        end
        for (int w = 0; w < 20000 && done_cnt == 0; w++) @(negedge clk);
        chk(busy == 1'b0, "R3 busy cleared", int'(busy), 0);
        if (manual) begin
            chk(cs_n[sel] == 1'b0, "R11 manual line held", int'(cs_n[sel]), 0);
            cs_level = 1'b1;
        end
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R3 single done", done_cnt, 1);
        chk(edges == 16 * burst, "R4 sclk edges", edges, 16 * burst);
        pops = (txc < burst) ? txc : burst;
        chk(tx_rd - base == pops, "R7 pop count", tx_rd - base, pops);
        chk(n_mo == burst, "R5 bytes seen on mosi", n_mo, burst);
        for (int i = 0; i < burst && i < 16; i++) begin
            if (i >= txc)
                chk(mosi_got[i] == 8'h00, "R7 dummy byte", int'(mosi_got[i]), 0);
            else
                chk(mosi_got[i] == exp_mosi(i, txc, base), "R5/R6 mosi byte",
                    int'(mosi_got[i]), int'(exp_mosi(i, txc, base)));
        end
        if (disc) begin
            chk(n_rx == 0, "R8 dropped pushes", n_rx, 0);
        end else begin
            chk(n_rx == burst, "R8 push count", n_rx, burst);
            for (int i = 0; i < burst && i < 16; i++)
                chk(rx_got[i] == slave_b[i], "R5/R6 rx byte", int'(rx_got[i]), int'(slave_b[i]));
        end
        if (!manual) begin
            chk(lead_gap >= HP, "R10 cs lead", lead_gap, HP);
            chk(trail_gap >= HP, "R10 cs trail", trail_gap, HP);
        end
        chk(cs_n == 4'hF, "R10/R11 lines released", int'(cs_n), 15);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(sclk == 1'b0 && mosi == 1'b0, "R1 pins at reset", int'({sclk, mosi}), 0);
        chk(cs_n == 4'hF, "R1 cs at reset", int'(cs_n), 15);
        chk(busy == 1'b0 && done == 1'b0, "R1 status at reset", int'({busy, done}), 0);
        chk(tx_pop == 1'b0 && rx_push == 1'b0, "R1 queues at reset", int'({tx_pop, rx_push}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: bus disabled
        cpol = 1'b1; burst_len = 24'd3; tx_len = 24'd0;
        @(negedge clk);
        chk(sclk == 1'b0, "R2 sclk gated low", int'(sclk), 0);
        any_edges = 0; done_cnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        chk(busy == 1'b0, "R2 start ignored", int'(busy), 0);
        chk(done_cnt == 0, "R2 no done", done_cnt, 0);
        chk(any_edges == 0, "R2 no sclk motion", any_edges, 0);
        bus_en = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R4 idle level cpol=1", int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R4 idle level cpol=0", int'(sclk), 0);

        // R9: zero-length burst
        burst_len = 24'd0; done_cnt = 0; any_edges = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R9 immediate done", int'({done, busy}), 2);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9 one done", done_cnt, 1);
        chk(any_edges == 0, "R9 no sclk motion", any_edges, 0);
        chk(cs_n == 4'hF, "R9 cs untouched", int'(cs_n), 15);

        // directed corners
        run_xfer(3, 3, 0, 0, 0, 0, 0, 0, 0, 1);   // repeated start
        run_xfer(2, 5, 1, 1, 1, 0, 3, 0, 0, 0);   // tx count above burst
        run_xfer(4, 1, 0, 1, 0, 1, 2, 0, 0, 0);   // dummy tail, discard
        run_xfer(2, 2, 1, 0, 0, 0, 1, 0, 1, 0);   // starved queue
        run_xfer(3, 2, 0, 0, 1, 0, 2, 1, 0, 0);   // manual chip select

        for (int n = 0; n < 20; n++) begin
            run_xfer(1 + int'($urandom % 6), int'($urandom % 8),
                     bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
                     bit'(($urandom % 4) == 0), int'($urandom % 4), 0, 0, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule